// File: doc/BRIEF.md
# Double-Buffered Tile Ping-Pong Controller

This controller sequences a tiled loop over two tile buffers. The fetch of the next tile overlaps the arithmetic on the current one. After a start pulse it asks a loader to fill buffer 0 with tile 0. This is the prologue, and no compute runs during it. When that fill reports done, the controller asks the compute engine to work on buffer 0. In the same cycle it asks the loader to fill buffer 1 with tile 1.

From then on, each iteration ends at a barrier. The barrier releases only when two events have been seen: the fill of the next tile has completed, and the compute on the current tile has completed. The two done pulses may come in any order, or in the same cycle. Each pulse is remembered until the barrier opens. At release the buffer roles swap. Compute moves to the freshly filled buffer, and the buffer just freed receives the tile after that.

No fill is requested past the final tile. A finished flag rises after the last compute completes. The buffer memories, the loader's address generation and the arithmetic sit outside this block.

Top module: `tile_pingpong_ctrl`

## Requirements
- R1: While idle or finished, a start pulse with a tile count N of at least 1 latches N. In the next cycle it produces a one-cycle fill request for buffer 0 (`fill_buf_o`=0), with no compute request, and it clears the finished flag.
- R2: When the prologue fill reports done, the next cycle carries a compute request for buffer 0. If N is at least 2, the same cycle also carries a fill request for buffer 1.
- R3: While tile i is being computed, no new compute request appears until the fill of tile i+1 and the compute of tile i have both reported done. The fill-done is not needed for the last tile. The done pulses are accepted in either order or together, and the release request appears in the cycle after the later one.
- R4: Tile i is always computed from buffer i mod 2, and tile i+1 is always filled into buffer (i+1) mod 2. Whenever a fill request and a compute request occur in the same cycle, their buffer indices differ.
- R5: No fill is requested for any tile at or beyond N. Exactly N fills and N computes are requested per job. The finished flag is high in the cycle after the last compute-done, and it stays high until the next start.
- R6: A start with N=0 raises the finished flag in the next cycle and requests neither a fill nor a compute.
- R7: With N=1, a job issues only the prologue fill and one compute on buffer 0, then finishes.
- R8: A start pulse during a job, and a compute-done pulse during the prologue, have no effect on the requests issued.
- R9: Fill and compute requests each last one cycle when the done inputs stay low in the cycle after them. Reset clears all requests and the finished flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job (sampled while idle or finished) |
| tile_count_i | input | CNT_W | Number of tiles in the job |
| fill_done_i | input | 1 | Loader reports the requested fill complete |
| comp_done_i | input | 1 | Compute engine reports the current tile complete |
| fill_req_o | output | 1 | One-cycle fill request |
| fill_buf_o | output | 1 | Buffer index for the fill request |
| comp_req_o | output | 1 | One-cycle compute request |
| comp_buf_o | output | 1 | Buffer index for the compute request |
| finished_o | output | 1 | All tiles computed |

## Verification
Every output comes from a register that samples the inputs at a rising edge. The response to a start or done pulse therefore appears exactly one cycle after the edge that captures it. The bench drives each pulse for one cycle from a falling edge and samples the outputs at the following falling edge, where the release, swap or finished result must already be present. It also samples at the falling edges that fall between the two done pulses of a barrier, where the compute request must still be absent.

// File: rtl/tile_pingpong_ctrl.sv
module tile_pingpong_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] tile_count_i,
  input  logic             fill_done_i,
  input  logic             comp_done_i,
  output logic             fill_req_o,
  output logic             fill_buf_o,
  output logic             comp_req_o,
  output logic             comp_buf_o,
  output logic             finished_o
);

  typedef enum logic [1:0] {S_IDLE, S_PRO, S_RUN, S_FIN} state_t;

  state_t           st;
  logic [CNT_W-1:0] idx, last;
  logic             fill_seen, comp_seen;

  wire              fill_ok  = fill_seen | fill_done_i;
  wire              comp_ok  = comp_seen | comp_done_i;
  wire              release_ = (st == S_RUN) && fill_ok && comp_ok;
  wire [CNT_W-1:0]  idx_nxt  = idx + {{(CNT_W-1){1'b0}}, 1'b1};
  wire              at_last  = (idx == last);
  wire              more     = (idx_nxt < last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      last       <= '0;
      fill_seen  <= 1'b0;
      comp_seen  <= 1'b0;
      fill_req_o <= 1'b0;
      fill_buf_o <= 1'b0;
      comp_req_o <= 1'b0;
      comp_buf_o <= 1'b0;
      finished_o <= 1'b0;
    end else begin
      fill_req_o <= 1'b0;
      comp_req_o <= 1'b0;
      case (st)
        S_IDLE, S_FIN: begin
          if (start_i) begin
            if (tile_count_i == '0) begin
              st         <= S_FIN;
              finished_o <= 1'b1;
            end else begin
              st         <= S_PRO;
              finished_o <= 1'b0;
              last       <= tile_count_i - {{(CNT_W-1){1'b0}}, 1'b1};
              fill_req_o <= 1'b1;
              fill_buf_o <= 1'b0;
            end
          end
        end
        S_PRO: begin
          if (fill_done_i) begin
            st         <= S_RUN;
            idx        <= '0;
            comp_req_o <= 1'b1;
            comp_buf_o <= 1'b0;
            comp_seen  <= 1'b0;
            if (last != '0) begin
              fill_req_o <= 1'b1;
              fill_buf_o <= 1'b1;
              fill_seen  <= 1'b0;
            end else begin
              fill_seen  <= 1'b1;
            end
          end
        end
        S_RUN: begin
          fill_seen <= fill_ok;
          comp_seen <= comp_ok;
          if (release_) begin
            if (at_last) begin
              st         <= S_FIN;
              finished_o <= 1'b1;
            end else begin
              idx        <= idx_nxt;
              comp_req_o <= 1'b1;
              comp_buf_o <= ~comp_buf_o;
              comp_seen  <= 1'b0;
              if (more) begin
                fill_req_o <= 1'b1;
                fill_buf_o <= comp_buf_o;
                fill_seen  <= 1'b0;
              end else begin
                fill_seen  <= 1'b1;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUFS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_o && comp_req_o) |-> (fill_buf_o != comp_buf_o)); // R4

  AST_SWAP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_req_o && $past(st == S_RUN)) |-> (comp_buf_o != $past(comp_buf_o))); // R4

  AST_COMP_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    comp_req_o |-> $past(fill_done_i || comp_done_i)); // R3

  AST_FILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_o |-> $past(start_i || fill_done_i || comp_done_i)); // R1

  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    finished_o |-> (!fill_req_o && !comp_req_o)); // R5

  AST_FIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished_o) |-> $past(start_i || comp_done_i)); // R5

endmodule

// File: tb/tile_pingpong_ctrl_tb.sv
module tile_pingpong_ctrl_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] tile_count_i = '0;
  logic fill_done_i = 1'b0;
  logic comp_done_i = 1'b0;
  logic fill_req_o, fill_buf_o, comp_req_o, comp_buf_o, finished_o;

  int errors = 0;
  int checks = 0;
  int nfill = 0;
  int ncomp = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tile_pingpong_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tile_count_i(tile_count_i),
    .fill_done_i(fill_done_i), .comp_done_i(comp_done_i),
    .fill_req_o(fill_req_o), .fill_buf_o(fill_buf_o),
    .comp_req_o(comp_req_o), .comp_buf_o(comp_buf_o), .finished_o(finished_o)
  );

  always @(negedge clk) begin
    if (fill_req_o) nfill++;
    if (comp_req_o) ncomp++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {27'd0, fill_req_o, fill_buf_o, comp_req_o, comp_buf_o, finished_o};
  endfunction

  // bit order of packed outputs: fill_req, fill_buf, comp_req, comp_buf, finished
  function automatic int pack(bit fr, bit fb, bit cr, bit cb, bit fin);
    return {27'd0, fr, fb, cr, cb, fin};
  endfunction

  task automatic pulse(input bit f, input bit c);
    fill_done_i = f;
    comp_done_i = c;
    @(negedge clk);
    fill_done_i = 1'b0;
    comp_done_i = 1'b0;
  endtask

  // mode 0: fill-done first, 1: compute-done first, 2: same cycle
  task automatic run_job(input int n, input int mode, input int exp_cnt);
    int e;
    nfill = 0;
    ncomp = 0;
    start_i = 1'b1;
    tile_count_i = n[CNT_W-1:0];
    @(negedge clk);
    start_i = 1'b0;
    if (n == 0) begin
      e = pack(0, 0, 0, 0, 1);
      chk((outs() & 5'b10101) == e, "R6", outs(), e);
      @(negedge clk);
      chk(nfill == 0 && ncomp == 0 && finished_o, "R6", nfill + ncomp, 0);
      return;
    end
    e = pack(1, 0, 0, 0, 0);
    chk((outs() & 5'b11101) == e, "R1", outs(), e);
    @(negedge clk);
    chk(!fill_req_o && !comp_req_o, "R9", outs(), 0);
    pulse(0, 1);
    chk(!comp_req_o && !fill_req_o, "R8", outs(), 0);
    pulse(1, 0);
    e = pack(n > 1, n > 1, 1, 0, 0);
    chk((outs() & (n > 1 ? 5'b11111 : 5'b10111)) == e, "R2", outs(), e);
    for (int i = 0; i < n; i++) begin
      bit more;
      more = (i + 1 < n);
      @(negedge clk);
      chk(!fill_req_o && !comp_req_o, "R9", outs(), 0);
      if (i == 0 && more) begin
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!fill_req_o && !comp_req_o, "R8", outs(), 0);
      end
      if (!more) pulse(0, 1);
      else if (mode == 2) pulse(1, 1);
      else begin
        pulse(mode == 0, mode == 1);
        chk(!comp_req_o, "R3", comp_req_o, 0);
        @(negedge clk);
        chk(!comp_req_o, "R3", comp_req_o, 0);
        pulse(mode == 1, mode == 0);
      end
      if (more) begin
        e = pack(i + 2 < n, (i + 2 < n) ? i % 2 : 0, 1, (i + 1) % 2, 0);
        chk((outs() & (i + 2 < n ? 5'b11111 : 5'b10111)) == e, "R4", outs(), e);
      end else begin
        e = pack(0, 0, 0, 0, 1);
        chk((outs() & 5'b10101) == e, "R5", outs(), e);
      end
    end
    @(negedge clk);
    @(negedge clk);
    chk(finished_o == 1'b1, "R5", finished_o, 1);
    chk(nfill == exp_cnt, n == 1 ? "R7" : "R5", nfill, exp_cnt);
    chk(ncomp == exp_cnt, n == 1 ? "R7" : "R5", ncomp, exp_cnt);
  endtask

  // columns: tile count, done order mode, expected fills (= computes)
  localparam int VEC [7][3] = '{
    '{1, 0, 1}, '{2, 0, 2}, '{2, 1, 2}, '{3, 2, 3},
    '{4, 1, 4}, '{5, 0, 5}, '{0, 0, 0}
  };

  initial begin
    repeat (2) @(negedge clk);
    chk(outs() == 0, "R9", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 0, "R9", outs(), 0);

    foreach (VEC[k]) run_job(VEC[k][0], VEC[k][1], VEC[k][2]);

    // directed: reset in the middle of a job clears requests and finished
    start_i = 1'b1;
    tile_count_i = 3;
    @(negedge clk);
    start_i = 1'b0;
    pulse(1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(outs() == 0, "R9", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse(1, 1);
    chk(!fill_req_o && !comp_req_o, "R8", outs(), 0);

    // directed: count one then zero back to back
    run_job(1, 2, 1);
    run_job(0, 0, 0);
    run_job(3, 0, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule